// File: doc/BRIEF.md
# Buffered Word Serializer

This block turns parallel words of a parameterized width into a single-bit stream, one bit per clock. Incoming words are written by a one-cycle strobe into a small queue. The queue absorbs short bursts that arrive faster than the serial line can drain them. A shift stage sends each word most significant bit first. A companion valid line marks every cycle that carries a data bit.

The queue is read only when the shift stage is idle or is sending the last bit of its current word. While words are waiting, the next word therefore starts on the cycle right after the previous word ends, with no gap. If a word arrives while the queue is full, it is discarded and a one-cycle drop pulse reports it. Over the long run, the average word rate must stay at or below one word per `WIDTH` clocks. The queue depth covers only short-term excess.

Top module: `word_serializer`

## Requirements
- R1: Every accepted word is sent in exactly `WIDTH` consecutive cycles with `ser_vld` high.
- R2: Bits of a word leave in descending order: bit `WIDTH-1` first, bit 0 last.
- R3: When another word is queued at the last bit of the current word, that word's first bit appears in the next cycle with no idle cycle between.
- R4: While `ser_vld` is low, `ser_bit` is 0.
- R5: The queue is read at most once in any `WIDTH` consecutive cycles. A read happens when the queue is non-empty and the shifter is either idle or on its last bit.
- R6: `in_vld` high while `fifo_full` is high produces a one-cycle `drop_pulse` in the following cycle. The word is discarded and the queued words are unaffected. A full queue refuses the word even if a read takes place in that same cycle.
- R7: An asynchronous active-low reset empties the queue, stops the shifter, and clears `ser_vld`, `ser_bit` and `drop_pulse`.
- R8: `fifo_full` is high exactly when `DEPTH` words are held, and `fifo_empty` is high exactly when none are held. `DEPTH` is a power of two and at least 2.
- R9: A word written into an empty queue while the shifter is idle shows its first bit in the cycle after the second rising edge following the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Write strobe for `in_word` |
| in_word | input | WIDTH | Parallel word to send |
| ser_bit | output | 1 | Serial data, MSB first |
| ser_vld | output | 1 | High on cycles carrying a data bit |
| drop_pulse | output | 1 | One-cycle pulse for a refused word |
| fifo_full | output | 1 | Queue holds DEPTH words |
| fifo_empty | output | 1 | Queue holds no words |

## Verification
The assertions assume that `rst_n` is released away from the clock edge and that `in_vld` and `in_word` are stable around each rising edge. They assume nothing about the input rate, because overload is a legal, reported condition. The stimulus changes inputs only on the falling edge and applies reset at that point as well. It drives directed bursts that overrun the queue, plus random traffic whose average rate is slightly above one word per `WIDTH` cycles. This mix exercises both continuous back-to-back output and drops without ever breaking the input timing the checks assume.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // index width for a queue of d entries (d is a power of two, >= 2)
  function automatic int unsigned ptr_bits(int unsigned d);
    return (d <= 2) ? 1 : $clog2(d);
  endfunction

  // width of a bit counter covering w positions
  function automatic int unsigned cnt_bits(int unsigned w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/ser_fifo.sv
module ser_fifo
  import ser_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int unsigned AW = ptr_bits(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wr_ptr_q, wr_ptr_d;
  logic [AW:0]      rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (wr_en) wr_ptr_d = wr_ptr_q + 1'b1;
    if (rd_en) rd_ptr_d = rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  // storage carries no reset; the pointers define what is valid
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ptr_q[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem_q[rd_ptr_q[AW-1:0]];
  assign empty   = (wr_ptr_q == rd_ptr_q);
  assign full    = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                   (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  output logic             ser_bit,
  output logic             ser_vld,
  output logic             busy,
  output logic             last
);
  localparam int unsigned CW = cnt_bits(WIDTH);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

  logic [WIDTH-1:0] sh_q, sh_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign last = busy_q && (cnt_q == LAST_IDX);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = load_word;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      sh_d = {sh_q[WIDTH-2:0], 1'b0};
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign ser_vld = busy_q;
  assign ser_bit = busy_q & sh_q[WIDTH-1];
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_word,
  output logic             ser_bit,
  output logic             ser_vld,
  output logic             drop_pulse,
  output logic             fifo_full,
  output logic             fifo_empty
);
  logic             wr_en, rd_en, busy, bit_last;
  logic [WIDTH-1:0] head_word;
  logic             drop_q, drop_d;

  // a full queue refuses input regardless of a same-cycle read
  assign wr_en  = in_vld && !fifo_full;
  assign rd_en  = !fifo_empty && (!busy || bit_last);
  assign drop_d = in_vld && fifo_full;

  ser_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (in_word),
    .rd_en   (rd_en),
    .rd_data (head_word),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  ser_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_en),
    .load_word (head_word),
    .ser_bit   (ser_bit),
    .ser_vld   (ser_vld),
    .busy      (busy),
    .last      (bit_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= drop_d;
  end

  assign drop_pulse = drop_q;
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic in_vld,
  input logic fifo_full,
  input logic fifo_empty,
  input logic drop_pulse,
  input logic ser_vld,
  input logic ser_bit,
  input logic rd_en,
  input logic bit_last
);
  localparam int unsigned SW = $clog2(WIDTH + 1);
  localparam logic [SW-1:0] SAT = SW'(WIDTH);

  // cycles since the last queue read, saturating at WIDTH
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_q <= SAT;
    else if (rd_en)            since_q <= SW'(1);
    else if (since_q != SAT)   since_q <= since_q + 1'b1;
  end

  a_r5_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (since_q == SAT));

  a_r5_read_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty && (!ser_vld || bit_last)) |-> rd_en);

  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_vld |-> !ser_bit);

  a_r6_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && fifo_full) |=> drop_pulse);

  a_r6_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_vld && fifo_full) |=> !drop_pulse);

  a_r3_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_last && !fifo_empty) |=> ser_vld);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  a_r1_last_ends_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_last && fifo_empty) |=> !ser_vld);
endmodule

bind word_serializer ser_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_vld     (in_vld),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .drop_pulse (drop_pulse),
  .ser_vld    (ser_vld),
  .ser_bit    (ser_bit),
  .rd_en      (rd_en),
  .bit_last   (bit_last)
);

// File: tb/test_word_serializer.sv
module test_word_serializer;
  localparam int W = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [W-1:0] in_word = '0;
  logic ser_bit, ser_vld, drop_pulse, fifo_full, fifo_empty;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state derived from the requirements
  logic [W-1:0] mq[$];
  logic [W-1:0] m_sh;
  int           m_cnt;
  bit           m_busy;
  bit           m_drop;

  always #5 clk = ~clk;

  word_serializer #(.WIDTH(W), .DEPTH(D)) i_word_serializer (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
    .ser_bit(ser_bit), .ser_vld(ser_vld), .drop_pulse(drop_pulse),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty)
  );

  function automatic logic exp_bit(logic [W-1:0] w, int idx);
    return w[W-1-idx];  // R2: MSB first
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    mq.delete();
    m_busy = 0; m_cnt = 0; m_sh = '0; m_drop = 0;
  endtask

  // compare ports with the model (called at a falling edge)
  task automatic compare();
    chk("R1/R3 ser_vld", ser_vld, m_busy);
    chk("R2/R4 ser_bit", ser_bit, m_busy ? exp_bit(m_sh, m_cnt) : 1'b0);
    chk("R6 drop_pulse", drop_pulse, m_drop);
    chk("R8 fifo_full", fifo_full, mq.size() == D);
    chk("R8 fifo_empty", fifo_empty, mq.size() == 0);
  endtask

  // drive one cycle of input and advance the model over the next rising edge
  task automatic cycle(bit v, logic [W-1:0] w);
    bit rd, wr;
    in_vld  = v;
    in_word = w;
    rd = (mq.size() > 0) && (!m_busy || m_cnt == W-1);   // R5
    wr = v && (mq.size() < D);                            // R6 full refuses
    m_drop = v && (mq.size() == D);
    if (rd) begin
      m_sh = mq.pop_front(); m_cnt = 0; m_busy = 1;
    end else if (m_busy) begin
      if (m_cnt == W-1) begin m_busy = 0; m_cnt = 0; end
      else m_cnt++;
    end
    if (wr) mq.push_back(w);
    @(negedge clk);
    compare();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    @(negedge clk);
    // R7: outputs cleared while reset is held
    chk("R7 ser_vld", ser_vld, 1'b0);
    chk("R7 ser_bit", ser_bit, 1'b0);
    chk("R7 drop_pulse", drop_pulse, 1'b0);
    chk("R8 empty after reset", fifo_empty, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R9: single word latency, R2 ordering with a distinctive pattern
    cycle(1, 8'hA5);
    chk("R9 not yet valid", ser_vld, 1'b0);
    cycle(0, '0);
    chk("R9 first bit", ser_bit, 1'b1);
    for (int i = 0; i < 12; i++) cycle(0, '0);

    // R6/R3: burst overruns the queue; back-to-back output
    for (int i = 0; i < D + 4; i++) cycle(1, W'(8'h81 + i * 8'h13));
    for (int i = 0; i < 6 * W; i++) cycle(0, '0);

    // corner words
    cycle(1, 8'hFF); cycle(1, 8'h00); cycle(1, 8'h01); cycle(1, 8'h80);
    for (int i = 0; i < 5 * W; i++) cycle(0, '0);

    // random traffic, average slightly above one word per W cycles
    for (int i = 0; i < 2000; i++) begin
      bit v = ($urandom % 7) == 0;
      cycle(v, W'($urandom));
    end

    // R7: asynchronous reset in the middle of traffic
    for (int i = 0; i < 3; i++) cycle(1, W'($urandom));
    #2 rst_n = 1'b0;
    #1;
    chk("R7 async ser_vld", ser_vld, 1'b0);
    chk("R7 async empty", fifo_empty, 1'b1);
    in_vld = 0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    compare();
    cycle(1, 8'h3C);
    for (int i = 0; i < 2 * W; i++) cycle(0, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule